// File: doc/BRIEF.md
# Bitwise Set/Clear Register

This block holds one 32-bit register that software can update either as a whole word or one bit at a time, with no read-modify-write sequence. The register is reached through a window of three adjacent word addresses on a simple register bus. The first address is the register itself. The second is a set alias: each bit written as one is forced high. The third is a clear alias: each bit written as one is forced low. A zero bit written to either alias leaves that bit of the register alone.

All three addresses read back the same stored value. The register is also driven onto a parallel output, so neighbouring logic can use it continuously, for example as an interrupt enable mask. Writes outside the window are dropped. Reads outside the window return zero.

The bus has no handshake. A write is taken on the rising clock edge where the write enable is high. Read data is combinational from the address and the stored value.

Top module: `setclr_reg`

## Requirements
- R1: While rst_ni is low the stored value, and therefore value_o, is all zeros.
- R2: A write to word address BASE_WORD (the plain register) replaces every stored bit with wdata_i.
- R3: A write to word address BASE_WORD+1 (set alias) makes each stored bit high where wdata_i is one, and leaves bits where wdata_i is zero unchanged.
- R4: A write to word address BASE_WORD+2 (clear alias) makes each stored bit low where wdata_i is one, and leaves bits where wdata_i is zero unchanged.
- R5: A read at any of the three window addresses returns the stored value on rdata_o.
- R6: A write to any address below BASE_WORD or above BASE_WORD+2 leaves the stored value unchanged.
- R7: A read at any address outside the three-word window returns zero on rdata_o.
- R8: A write changes value_o and the read data only after the rising edge at which we_i is sampled high. From the next cycle on, value_o and reads return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (10) | Word address for reads and writes |
| we_i | input | 1 | Write enable, sampled on the rising edge |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Combinational read data |
| value_o | output | DATA_W (32) | Current stored register value |

## Verification
The assertions check the update rule on every clock edge, for every bit:
- a plain write replaces the value;
- a set write ORs wdata_i into the stored value;
- a clear write masks the stored value with the inverse of wdata_i;
- a write outside the window leaves value_o stable.

They also check that every read is either the stored value or zero, depending on the address window. Only the directed scenarios show the rest: specific edge addresses just outside the window, alias writes of all-zero data, and the exact cycle at which a change first appears. They also check the absolute reset value of the outputs against values the bench computes itself.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_MAIN = 2'd1,
    ACC_SET  = 2'd2,
    ACC_CLR  = 2'd3
  } acc_e;
endpackage

// File: rtl/setclr_decode.sv
module setclr_decode
  import setclr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BASE_WORD = 'h040
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              kind_o,
  output logic              in_win_o
);
  localparam logic [ADDR_W-1:0] BASE = BASE_WORD[ADDR_W-1:0];

  logic [ADDR_W-1:0] ofs;

  assign ofs      = addr_i - BASE;
  assign in_win_o = (addr_i >= BASE) && (ofs < ADDR_W'(3));

  always_comb begin
    kind_o = ACC_NONE;
    if (in_win_o) begin
      case (ofs[1:0])
        2'd0:    kind_o = ACC_MAIN;
        2'd1:    kind_o = ACC_SET;
        2'd2:    kind_o = ACC_CLR;
        default: kind_o = ACC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/setclr_next.sv
module setclr_next
  import setclr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  acc_e              kind_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] nxt_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    always_comb begin
      case (kind_i)
        ACC_MAIN: nxt_o[g] = wdata_i[g];
        ACC_SET:  nxt_o[g] = cur_i[g] | wdata_i[g];
        ACC_CLR:  nxt_o[g] = cur_i[g] & ~wdata_i[g];
        default:  nxt_o[g] = cur_i[g];
      endcase
    end
  end
endmodule

// File: rtl/setclr_store.sv
module setclr_store #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/setclr_reg.sv
module setclr_reg
  import setclr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BASE_WORD = 'h040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] value_o
);
  acc_e              kind;
  logic              in_win;
  logic [DATA_W-1:0] cur_q;
  logic [DATA_W-1:0] nxt;

  setclr_decode #(.ADDR_W(ADDR_W), .BASE_WORD(BASE_WORD)) u_dec (
    .addr_i  (addr_i),
    .kind_o  (kind),
    .in_win_o(in_win)
  );

  setclr_next #(.DATA_W(DATA_W)) u_next (
    .kind_i (kind),
    .cur_i  (cur_q),
    .wdata_i(wdata_i),
    .nxt_o  (nxt)
  );

  setclr_store #(.DATA_W(DATA_W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (we_i & in_win),
    .d_i   (nxt),
    .q_o   (cur_q)
  );

  // all three window addresses alias the same storage on read
  assign rdata_o = in_win ? cur_q : '0;
  assign value_o = cur_q;
endmodule

// File: rtl/setclr_reg_chk.sv
module setclr_reg_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BASE_WORD = 'h040
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] value_o
);
  localparam logic [ADDR_W:0] A_MAIN = (ADDR_W+1)'(BASE_WORD);
  localparam logic [ADDR_W:0] A_SET  = A_MAIN + 1'b1;
  localparam logic [ADDR_W:0] A_CLR  = A_MAIN + 2'd2;

  logic [ADDR_W:0] a_ext;
  logic            win;
  assign a_ext = {1'b0, addr_i};
  assign win   = (a_ext == A_MAIN) || (a_ext == A_SET) || (a_ext == A_CLR);

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> value_o == '0);

  assert_main_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && a_ext == A_MAIN |=> value_o == $past(wdata_i));

  assert_set_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && a_ext == A_SET |=> value_o == ($past(value_o) | $past(wdata_i)));

  assert_clr_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && a_ext == A_CLR |=> value_o == ($past(value_o) & ~$past(wdata_i)));

  assert_win_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win |-> rdata_o == value_o);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && win) |=> $stable(value_o));

  assert_out_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win |-> rdata_o == '0);
endmodule

bind setclr_reg setclr_reg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_WORD(BASE_WORD)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .value_o(value_o)
);

// File: tb/setclr_reg_tb_top.sv
`timescale 1ns/1ps
module setclr_reg_tb_top;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 10;
  localparam int unsigned BASE = 'h040;
  localparam logic [AW-1:0] A_MAIN = AW'(BASE);
  localparam logic [AW-1:0] A_SET  = AW'(BASE + 1);
  localparam logic [AW-1:0] A_CLR  = AW'(BASE + 2);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o, value_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] model = '0;

  always #2 clk_i = ~clk_i;

  setclr_reg #(.DATA_W(DW), .ADDR_W(AW), .BASE_WORD(BASE)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .value_o(value_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, commit on rising edge, settle 1 ns after
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk_i);
    addr_i = a; #1;
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [DW-1:0] r;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 check("R1 value_o in reset", value_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    model = '0;
    bus_read(A_MAIN, r);
    check("R1 read after reset", r, '0);
  endtask

  task automatic t_main;
    logic [DW-1:0] r;
    bus_write(A_MAIN, 32'hA5A5_0F0F); model = 32'hA5A5_0F0F;
    check("R2 main write", value_o, model);
    bus_write(A_MAIN, 32'h0000_0001); model = 32'h0000_0001;
    check("R2 main overwrite", value_o, model);
    bus_read(A_MAIN, r);
    check("R5 read main", r, model);
  endtask

  task automatic t_set;
    logic [DW-1:0] r;
    bus_write(A_SET, 32'h8000_0100); model = model | 32'h8000_0100;
    check("R3 set bits", value_o, model);
    bus_write(A_SET, 32'h0);
    check("R3 set zero no change", value_o, model);
    bus_write(A_SET, 32'hFFFF_FFFF); model = 32'hFFFF_FFFF;
    check("R3 set all", value_o, model);
    bus_read(A_SET, r);
    check("R5 read set alias", r, model);
  endtask

  task automatic t_clr;
    logic [DW-1:0] r;
    bus_write(A_CLR, 32'h0F00_00F0); model = model & ~32'h0F00_00F0;
    check("R4 clear bits", value_o, model);
    bus_write(A_CLR, 32'h0);
    check("R4 clear zero no change", value_o, model);
    bus_read(A_CLR, r);
    check("R5 read clr alias", r, model);
    bus_write(A_CLR, 32'hFFFF_FFFF); model = '0;
    check("R4 clear all", value_o, model);
  endtask

  task automatic t_outside;
    logic [DW-1:0] r;
    bus_write(A_MAIN, 32'h1234_5678); model = 32'h1234_5678;
    bus_write(AW'(BASE - 1), 32'hFFFF_FFFF);
    check("R6 write below window", value_o, model);
    bus_write(AW'(BASE + 3), 32'h0000_0000);
    check("R6 write above window", value_o, model);
    bus_read(AW'(BASE - 1), r);
    check("R7 read below window", r, '0);
    bus_read(AW'(BASE + 3), r);
    check("R7 read above window", r, '0);
    bus_read(AW'(0), r);
    check("R7 read address zero", r, '0);
  endtask

  task automatic t_timing;
    logic [DW-1:0] r;
    @(negedge clk_i);
    addr_i = A_SET; wdata_i = 32'h0000_8000; we_i = 1'b1;
    #1 check("R8 no change before edge", value_o, model);
    check("R8 read before edge", rdata_o, model);
    @(posedge clk_i); #1;
    we_i = 1'b0;
    model = model | 32'h0000_8000;
    check("R8 value after edge", value_o, model);
    bus_read(A_MAIN, r);
    check("R8 next read sees new value", r, model);
  endtask

  initial begin
    #1;
    t_reset();
    t_main();
    t_set();
    t_clr();
    t_outside();
    t_timing();
    repeat (2) @(posedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule